// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single timer channel that software reaches through a small register bus. A down-counter steps once for each pulse on the selected tick-enable input. When a step finds the count at zero, the counter underflows and the interrupt flag goes high. On underflow the counter either reloads from a stored load value (periodic mode) or wraps to all ones (free-running mode). The interrupt output is a level that stays high until software writes to the clear address.

Two tick-enable inputs come from outside the block, one fast and one slow, and a control bit picks which one drives the counter. Clock division and interrupt routing are left to the surrounding logic. The counter width is a parameter, and instances of 16 and 32 bits are both expected.

Top module: `timer_chan`

## Requirements
- R1: Registers are decoded on the full 4-bit address: 0x0 is load (read/write), 0x4 is the count (read-only), 0x8 is control (read/write; it reads back only bits 7, 6 and 3, with all other bits zero), and 0xC is interrupt clear (write-only, reads 0). Any other address reads 0 and ignores writes.
- R2: Control bit 7 is the enable. While it is 0, the count does not change on ticks and no new interrupt is raised.
- R3: When control bit 6 is 1 (periodic), a step taken at count zero loads the count from the load register.
- R4: When control bit 3 is 1, steps follow `tick_fast`. When it is 0, steps follow `tick_slow`, and the unselected input has no effect.
- R5: Each enabled, selected tick lowers the count by one. A step taken at count zero sets `irq` one cycle later.
- R6: A write of any data value to address 0xC clears `irq` on the next cycle.
- R7: The count and load registers are CNT_W bits wide (16 or 32). Load data bits above CNT_W are dropped.
- R8: When control bit 6 is 0 (free-running), a step taken at count zero sets the count to all ones.
- R9: A load write while the channel is disabled also copies the value into the count. While the channel is enabled, a load write changes only the load register.
- R10: If an underflow and a clear write fall in the same cycle, `irq` is high afterwards.
- R11: A read of address 0x4 returns the live count, zero-extended to 32 bits, in the same cycle.
- R12: After reset, the load, count and control registers are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_fast | input | 1 | Fast-rate tick enable |
| tick_slow | input | 1 | Slow-rate tick enable |
| irq | output | 1 | Underflow interrupt, level, held until cleared |

## Verification
The assertions assume that each tick input is a single-cycle enable sampled on `clk`. They also assume that a bus write lasts exactly one cycle, so that every write strobe is one register update. The bench drives ticks and bus strobes on the falling edge and drops them right after one rising edge. Read strobes never carry a write.

// File: rtl/timer_chan.sv
module timer_chan #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_fast,
  input  logic        tick_slow,
  output logic        irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] load_q, cnt_q;
  logic ctl_en, ctl_per, ctl_fast;

  wire wr     = bus_sel & bus_wr;
  wire wr_ld  = wr && bus_addr == 4'h0;
  wire wr_ctl = wr && bus_addr == 4'h8;
  wire wr_clr = wr && bus_addr == 4'hC;
  wire tick   = ctl_fast ? tick_fast : tick_slow;
  wire step   = ctl_en & tick;
  wire at_zero = cnt_q == '0;
  wire uflow  = step & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= '0;
      cnt_q    <= '0;
      ctl_en   <= 1'b0;
      ctl_per  <= 1'b0;
      ctl_fast <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ld) load_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctl) begin
        ctl_en   <= bus_wdata[7];
        ctl_per  <= bus_wdata[6];
        ctl_fast <= bus_wdata[3];
      end
      if (step)
        cnt_q <= at_zero ? (ctl_per ? load_q : ALL_ONES) : cnt_q - 1'b1;
      else if (wr_ld && !ctl_en)
        cnt_q <= bus_wdata[CNT_W-1:0];
      if (uflow)       irq <= 1'b1;
      else if (wr_clr) irq <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = 32'(load_q);
      4'h4:    bus_rdata = 32'(cnt_q);
      4'h8:    bus_rdata = {24'd0, ctl_en, ctl_per, 2'b00, ctl_fast, 3'b000};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             tick_fast,
  input logic             tick_slow,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             ctl_en,
  input logic             ctl_per,
  input logic             ctl_fast
);
  logic sel_tick, ld_wr, clr_wr;
  assign sel_tick = ctl_fast ? tick_fast : tick_slow;
  assign ld_wr  = bus_sel && bus_wr && bus_addr == 4'h0;
  assign clr_wr = bus_sel && bus_wr && bus_addr == 4'hC;

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !ld_wr) |=> $stable(cnt_q)); // R2
  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(ctl_en && sel_tick && cnt_q == '0)) |=> !irq); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && sel_tick && cnt_q == '0 && ctl_per) |=> cnt_q == $past(load_q)); // R3
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && sel_tick && cnt_q == '0 && !ctl_per) |=> cnt_q == {CNT_W{1'b1}}); // R8
  AST_UNSELECTED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !ctl_fast && !tick_slow) |=> $stable(cnt_q)); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(ctl_en && sel_tick && cnt_q == '0)) |=> !irq); // R6
  AST_UFLOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && sel_tick && cnt_q == '0) |=> irq); // R10
  AST_VALUE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'h4) |-> bus_rdata == 32'(cnt_q)); // R11
endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
  .tick_slow(tick_slow), .irq(irq), .cnt_q(cnt_q), .load_q(load_q),
  .ctl_en(ctl_en), .ctl_per(ctl_per), .ctl_fast(ctl_fast)
);

// File: tb/tb_timer_chan.sv
module tb_timer_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'd0, rdata, rdata16;
  logic tick_fast = 1'b0, tick_slow = 1'b0;
  logic irq, irq16;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  timer_chan #(.CNT_W(32)) dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq));
  timer_chan #(.CNT_W(16)) dut16 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata16),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq16));

  // {load, ctl, fast ticks, expected count, expected irq}; ctl: 0x80 en, 0x40 periodic, 0x08 fast
  localparam logic [80:0] VEC [8] = '{
    {32'd10, 8'hC8, 8'd3, 32'd7,        1'b0},
    {32'd10, 8'h48, 8'd3, 32'd10,       1'b0},
    {32'd10, 8'h80, 8'd3, 32'd10,       1'b0},
    {32'd2,  8'hC8, 8'd3, 32'd2,        1'b1},
    {32'd2,  8'h88, 8'd3, 32'hFFFFFFFF, 1'b1},
    {32'd0,  8'hC8, 8'd1, 32'd0,        1'b1},
    {32'd5,  8'h88, 8'd5, 32'd0,        1'b0},
    {32'd3,  8'hC8, 8'd9, 32'd2,        1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h4;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
  endtask

  task automatic ticks(input logic f, input logic s, input int n);
    @(negedge clk);
    tick_fast = f; tick_slow = s;
    repeat (n) @(posedge clk);
    #1 tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state, R1 decode
    rd(4'h0); chk("R12 load", rdata, 0);
    rd(4'h4); chk("R12 count", rdata, 0);
    rd(4'h8); chk("R12 ctl", rdata, 0);
    chk("R12 irq", {31'd0, irq}, 0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8); chk("R1 ctl readback", rdata, 32'hC8);
    wr(4'h8, 0);
    wr(4'h3, 32'h55);
    rd(4'hC); chk("R1 clear reads zero", rdata, 0);
    rd(4'h3); chk("R1 unmapped", rdata, 0);

    for (int i = 0; i < 8; i++) begin
      wr(4'h8, 0);
      wr(4'hC, 32'd0);
      wr(4'h0, VEC[i][80:49]);
      wr(4'h8, {24'd0, VEC[i][48:41]});
      ticks(1'b1, 1'b0, int'(VEC[i][40:33]));
      rd(4'h4); chk($sformatf("R3/R5/R8 vec%0d count", i), rdata, VEC[i][32:1]);
      chk($sformatf("R2/R4/R5 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R4 slow source
    wr(4'h8, 0); wr(4'hC, 0); wr(4'h0, 10); wr(4'h8, 32'h80);
    ticks(1'b0, 1'b1, 2);
    rd(4'h4); chk("R4 slow ticks", rdata, 8);
    // R9 load while enabled leaves count
    wr(4'h0, 50);
    rd(4'h4); chk("R9 enabled load count", rdata, 8);
    rd(4'h0); chk("R9 enabled load reg", rdata, 50);
    wr(4'h8, 0); wr(4'h0, 100);
    rd(4'h4); chk("R9 disabled load count", rdata, 100);

    // R10 underflow and clear same cycle; R6 clear with arbitrary data
    wr(4'h0, 1); wr(4'h8, 32'hC8);
    ticks(1'b1, 1'b0, 1);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'hDEAD_BEEF; tick_fast = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; tick_fast = 1'b0;
    chk("R10 irq kept", {31'd0, irq}, 1);
    wr(4'hC, 32'hDEAD_BEEF);
    chk("R6 irq cleared", {31'd0, irq}, 0);
    // R2 disabled at zero: no new irq
    wr(4'h8, 0); wr(4'h0, 0);
    ticks(1'b1, 1'b1, 3);
    chk("R2 no irq disabled", {31'd0, irq}, 0);
    rd(4'h4); chk("R2 count held", rdata, 0);

    // R7 / R11 / R8 on 16-bit instance
    wr(4'h0, 32'h0001_2345);
    rd(4'h0); chk("R7 16-bit load", rdata16, 32'h2345);
    rd(4'h4); chk("R11 16-bit count", rdata16, 32'h2345);
    wr(4'h8, 0); wr(4'hC, 0); wr(4'h0, 1); wr(4'h8, 32'h88);
    ticks(1'b1, 1'b0, 2);
    rd(4'h4); chk("R8/R11 16-bit wrap", rdata16, 32'h0000_FFFF);
    chk("R5 16-bit irq", {31'd0, irq16}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule